// File: doc/BRIEF.md
# Multi-Rate Limit Monitor Scheduler

This block watches a set of analog readings, held as raw converter codes, and flags readings that leave their allowed band. Each channel has two bands: an outer fault band and an inner warning band, each with a high and a low limit. The block never waits on the converter. When a check falls due it takes whatever value is currently on the reading bus.

Channels are grouped into four classes: rail output voltage, rail output current, input voltage, and temperature (auxiliary readings go in this last class). Each class has its own check interval. All intervals are counted in ticks of a microsecond timer derived from the system clock. The current interval grows with the number of rails in use. When several classes fall due together, a scheduler serves them one channel per cycle in a fixed order.

Warning and fault flags stay set until software-side logic clears them with a per-channel clear input. A fault event pulse reports each newly set fault flag together with its channel index. That pulse drives whatever later logic chooses a response.

Top module: `limit_monitor`

## Requirements
- R1: After reset, every warning and fault flag is 0 and `faultEvt` is 0.
- R2: At a check of channel c, its fault flag sets when the reading is strictly above its fault high limit or strictly below its fault low limit. The reading used is the value present on `adcData` in the cycle of the check.
- R3: At the same check, the warning flag sets under the same rule, using the warning limits. It is independent of the fault flag.
- R4: A set flag stays set while the reading returns inside its band.
- R5: A one-cycle pulse on `clrIn[c]` clears both flags of channel c and leaves every other channel's flags unchanged.
- R6: Output-voltage channels are checked every VOUT_US ticks. One tick is TICK_DIV clock cycles.
- R7: Output-current channels are checked every VOUT_US × activeRails ticks. An `activeRails` value of 0 acts as 1.
- R8: The input-voltage channel is checked every VIN_US ticks. Temperature and auxiliary channels are checked every TEMP_US ticks.
- R9: Channel indices are fixed as follows: voltage of rail r is r; current of rail r is NUM_RAILS+r; input voltage is 2·NUM_RAILS; temperature/auxiliary k is 2·NUM_RAILS+1+k. Classes due together are served voltage, then current, then input voltage, then temperature, one channel per cycle.
- R10: `faultEvt` pulses for one cycle in the same cycle that a fault flag goes from 0 to 1, with `faultChan` set to that channel's index. It does not pulse again while that flag stays set.
- R11: Voltage and current channels of rails numbered activeRails or higher are never checked, so their flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| activeRails | input | RAIL_W | Number of rails in use |
| adcData | input | NCH·W | Latest reading for each channel; channel c occupies bits c·W upward |
| faultHiLim | input | NCH·W | Per-channel fault high limit |
| faultLoLim | input | NCH·W | Per-channel fault low limit |
| warnHiLim | input | NCH·W | Per-channel warning high limit |
| warnLoLim | input | NCH·W | Per-channel warning low limit |
| clrIn | input | NCH | Per-channel flag clear |
| warnFlags | output | NCH | Sticky warning flags |
| faultFlags | output | NCH | Sticky fault flags |
| faultEvt | output | 1 | One-cycle pulse on a newly set fault flag |
| faultChan | output | CH_W | Channel index carried with `faultEvt` |

## Verification
The bench sweeps every code of one channel across fixed limits. A comparator with an off-by-one limit, or with the wrong compare direction, would misflag exactly the boundary codes. The bench measures the cycle distance between successive fault events of a channel for each class and for several rail counts. A wrong interval, a current interval that ignores the rail count, or a mishandled zero rail count would show up as a wrong period. It also checks the order of events when voltage and current checks fall due together. It checks that inactive rails and uncleared neighbours stay untouched, and that a fault flag held set produces no repeated events. A scheduler with reversed priority, a clear with too wide a reach, or a strobe tied to the comparison rather than to the flag's rise would each fail one of these checks.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int CHAN_BITS = 8;
  localparam int NCLS = 4;
  // Strobes from scheduler to evaluator
  typedef struct packed {
    logic                 check;
    logic [CHAN_BITS-1:0] chan;
  } chkStrobe_t;
endpackage

// File: rtl/lm_sched.sv
module lm_sched
  import lm_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter int NUM_TEMPS = 5,
  parameter int TICK_DIV  = 100,
  parameter int VOUT_US   = 200,
  parameter int VIN_US    = 1000,
  parameter int TEMP_US   = 100000,
  parameter int RAIL_W    = $clog2(NUM_RAILS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RAIL_W-1:0] activeRails,
  output chkStrobe_t        strobe
);
  localparam int DIV_W  = $clog2(TICK_DIV + 1);
  localparam int CUR_MX = VOUT_US * NUM_RAILS;
  localparam int LIM_A  = (CUR_MX > VIN_US) ? CUR_MX : VIN_US;
  localparam int LIM_MX = (LIM_A > TEMP_US) ? LIM_A : TEMP_US;
  localparam int CNT_W  = $clog2(LIM_MX + 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [RAIL_W-1:0] arEff;
  logic [CNT_W-1:0] lim [NCLS];
  logic [NCLS-1:0]  due, pend, grantOh;
  logic [CHAN_BITS-1:0] base [NCLS];
  logic [CHAN_BITS-1:0] last [NCLS];
  logic [CHAN_BITS-1:0] idx, lastIdx, grantBase, grantLast;
  logic             busy, start;

  always_comb begin
    if (activeRails == '0) arEff = RAIL_W'(1);
    else if (int'(activeRails) > NUM_RAILS) arEff = RAIL_W'(NUM_RAILS);
    else arEff = activeRails;
  end

  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN || tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    lim[0]  = CNT_W'(VOUT_US);
    lim[1]  = CNT_W'(VOUT_US * int'(arEff));
    lim[2]  = CNT_W'(VIN_US);
    lim[3]  = CNT_W'(TEMP_US);
    base[0] = '0;
    base[1] = CHAN_BITS'(NUM_RAILS);
    base[2] = CHAN_BITS'(2 * NUM_RAILS);
    base[3] = CHAN_BITS'(2 * NUM_RAILS + 1);
    last[0] = CHAN_BITS'(int'(arEff) - 1);
    last[1] = CHAN_BITS'(NUM_RAILS + int'(arEff) - 1);
    last[2] = CHAN_BITS'(2 * NUM_RAILS);
    last[3] = CHAN_BITS'(2 * NUM_RAILS + NUM_TEMPS);
  end

  // One interval counter per measurement class
  for (genvar g = 0; g < NCLS; g++) begin : gInterval
    logic [CNT_W-1:0] ivCnt;
    logic             wrap;
    assign wrap   = (ivCnt >= lim[g] - 1'b1);
    assign due[g] = tick && wrap;
    always_ff @(posedge clk) begin
      if (!rstN) ivCnt <= '0;
      else if (tick) ivCnt <= wrap ? '0 : ivCnt + 1'b1;
    end
  end

  // Fixed priority: lowest class number wins
  always_comb begin
    grantOh   = '0;
    grantBase = '0;
    grantLast = '0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grantOh   = NCLS'(1) << i;
        grantBase = base[i];
        grantLast = last[i];
      end
    end
  end

  assign start = !busy && (pend != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= '0;
      busy    <= 1'b0;
      idx     <= '0;
      lastIdx <= '0;
    end else begin
      pend <= (pend & ~(start ? grantOh : '0)) | due;
      if (start) begin
        busy    <= 1'b1;
        idx     <= grantBase;
        lastIdx <= grantLast;
      end else if (busy) begin
        if (idx == lastIdx) busy <= 1'b0;
        else idx <= idx + 1'b1;
      end
    end
  end

  assign strobe.check = busy;
  assign strobe.chan  = idx;
endmodule

// File: rtl/lm_eval.sv
module lm_eval
  import lm_pkg::*;
#(
  parameter int NCH  = 14,
  parameter int W    = 12,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  chkStrobe_t      strobe,
  input  logic [NCH*W-1:0] adcData,
  input  logic [NCH*W-1:0] faultHiLim,
  input  logic [NCH*W-1:0] faultLoLim,
  input  logic [NCH*W-1:0] warnHiLim,
  input  logic [NCH*W-1:0] warnLoLim,
  input  logic [NCH-1:0]  clrIn,
  output logic [NCH-1:0]  warnFlags,
  output logic [NCH-1:0]  faultFlags,
  output logic            faultEvt,
  output logic [CH_W-1:0] faultChan
);
  logic [NCH-1:0]  hitOh;
  logic [W-1:0]    rd, fHi, fLo, wHi, wLo;
  logic [CH_W-1:0] chanEnc;
  logic            isFault, isWarn, newFault;

  always_comb begin
    hitOh   = '0;
    rd      = '0;
    fHi     = '0;
    fLo     = '0;
    wHi     = '0;
    wLo     = '0;
    chanEnc = '0;
    for (int i = 0; i < NCH; i++) begin
      if (strobe.check && strobe.chan == CHAN_BITS'(i)) begin
        hitOh[i] = 1'b1;
        rd       = adcData[i*W +: W];
        fHi      = faultHiLim[i*W +: W];
        fLo      = faultLoLim[i*W +: W];
        wHi      = warnHiLim[i*W +: W];
        wLo      = warnLoLim[i*W +: W];
        chanEnc  = CH_W'(i);
      end
    end
  end

  assign isFault  = (hitOh != '0) && ((rd > fHi) || (rd < fLo));
  assign isWarn   = (hitOh != '0) && ((rd > wHi) || (rd < wLo));
  assign newFault = isFault && ((hitOh & ~faultFlags) != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnFlags  <= '0;
      faultFlags <= '0;
      faultEvt   <= 1'b0;
      faultChan  <= '0;
    end else begin
      faultFlags <= (faultFlags & ~clrIn) | (isFault ? hitOh : '0);
      warnFlags  <= (warnFlags & ~clrIn) | (isWarn ? hitOh : '0);
      faultEvt   <= newFault;
      faultChan  <= chanEnc;
    end
  end
endmodule

// File: rtl/limit_monitor.sv
module limit_monitor
  import lm_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter int NUM_TEMPS = 5,
  parameter int W         = 12,
  parameter int TICK_DIV  = 100,
  parameter int VOUT_US   = 200,
  parameter int VIN_US    = 1000,
  parameter int TEMP_US   = 100000,
  localparam int NCH      = 2 * NUM_RAILS + 1 + NUM_TEMPS,
  localparam int CH_W     = $clog2(NCH),
  localparam int RAIL_W   = $clog2(NUM_RAILS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RAIL_W-1:0] activeRails,
  input  logic [NCH*W-1:0]  adcData,
  input  logic [NCH*W-1:0]  faultHiLim,
  input  logic [NCH*W-1:0]  faultLoLim,
  input  logic [NCH*W-1:0]  warnHiLim,
  input  logic [NCH*W-1:0]  warnLoLim,
  input  logic [NCH-1:0]    clrIn,
  output logic [NCH-1:0]    warnFlags,
  output logic [NCH-1:0]    faultFlags,
  output logic              faultEvt,
  output logic [CH_W-1:0]   faultChan
);
  chkStrobe_t strobe;

  lm_sched #(
    .NUM_RAILS(NUM_RAILS), .NUM_TEMPS(NUM_TEMPS), .TICK_DIV(TICK_DIV),
    .VOUT_US(VOUT_US), .VIN_US(VIN_US), .TEMP_US(TEMP_US), .RAIL_W(RAIL_W)
  ) u_sched (
    .clk(clk), .rstN(rstN), .activeRails(activeRails), .strobe(strobe)
  );

  lm_eval #(.NCH(NCH), .W(W), .CH_W(CH_W)) u_eval (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcData(adcData),
    .faultHiLim(faultHiLim), .faultLoLim(faultLoLim),
    .warnHiLim(warnHiLim), .warnLoLim(warnLoLim), .clrIn(clrIn),
    .warnFlags(warnFlags), .faultFlags(faultFlags),
    .faultEvt(faultEvt), .faultChan(faultChan)
  );
endmodule

// File: rtl/lm_chk.sv
module lm_chk #(
  parameter int NCH  = 14,
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [NCH-1:0]  clrIn,
  input logic [NCH-1:0]  warnFlags,
  input logic [NCH-1:0]  faultFlags,
  input logic            faultEvt,
  input logic [CH_W-1:0] faultChan
);
  logic [NCH-1:0] prevFault;
  logic [NCH-1:0] risen;

  always_ff @(posedge clk) begin
    if (!rstN) prevFault <= '0;
    else prevFault <= faultFlags;
  end

  assign risen = faultFlags & ~prevFault;

  AST_EVT_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    faultEvt |-> (int'(faultChan) < NCH) && risen[faultChan]); // R10

  AST_RISE_GIVES_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (risen != '0) |-> faultEvt); // R10

  AST_ONE_CHAN_PER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(risen) <= 1); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(faultFlags) & ~$past(clrIn)) & ~faultFlags) == '0)); // R4

  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(warnFlags) & ~$past(clrIn)) & ~warnFlags) == '0)); // R4
endmodule

bind limit_monitor lm_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .clrIn(clrIn), .warnFlags(warnFlags),
  .faultFlags(faultFlags), .faultEvt(faultEvt), .faultChan(faultChan)
);

// File: tb/tb_limit_monitor.sv
`timescale 1ns/1ps
module tb_limit_monitor;
  localparam int NR = 2, NT = 2, W = 8, DIV = 4;
  localparam int VUS = 5, VINUS = 20, TUS = 60;
  localparam int NCH = 2 * NR + 1 + NT;
  localparam int CW = $clog2(NCH);
  localparam int RW = $clog2(NR + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [RW-1:0] activeRails = RW'(NR);
  logic [NCH*W-1:0] adcData, faultHiLim, faultLoLim, warnHiLim, warnLoLim;
  logic [NCH-1:0] clrIn = '0;
  logic [NCH-1:0] warnFlags, faultFlags;
  logic faultEvt;
  logic [CW-1:0] faultChan;

  logic [W-1:0] rd [NCH];
  logic [W-1:0] fh [NCH];
  logic [W-1:0] fl [NCH];
  logic [W-1:0] wh [NCH];
  logic [W-1:0] wl [NCH];

  int nChecks = 0, nFails = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      adcData[i*W +: W]    = rd[i];
      faultHiLim[i*W +: W] = fh[i];
      faultLoLim[i*W +: W] = fl[i];
      warnHiLim[i*W +: W]  = wh[i];
      warnLoLim[i*W +: W]  = wl[i];
    end
  end

  limit_monitor #(
    .NUM_RAILS(NR), .NUM_TEMPS(NT), .W(W), .TICK_DIV(DIV),
    .VOUT_US(VUS), .VIN_US(VINUS), .TEMP_US(TUS)
  ) dut (
    .clk(clk), .rstN(rstN), .activeRails(activeRails), .adcData(adcData),
    .faultHiLim(faultHiLim), .faultLoLim(faultLoLim),
    .warnHiLim(warnHiLim), .warnLoLim(warnLoLim), .clrIn(clrIn),
    .warnFlags(warnFlags), .faultFlags(faultFlags),
    .faultEvt(faultEvt), .faultChan(faultChan)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseClr(input logic [NCH-1:0] m);
    @(negedge clk) clrIn = m;
    @(negedge clk) clrIn = '0;
  endtask

  // Wait for a fault event on channel c (c < 0 means any channel)
  task automatic waitEvt(input int c, output int t, output int ch);
    t = -1;
    ch = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (faultEvt && (c < 0 || int'(faultChan) == c)) begin
        t = cyc;
        ch = int'(faultChan);
        return;
      end
    end
  endtask

  task automatic measure(input int c, input int expP, input string tag);
    int t1, t2, ch;
    pulseClr(NCH'(1) << c);
    rd[c] = 8'd255;
    waitEvt(c, t1, ch);
    pulseClr(NCH'(1) << c);
    waitEvt(c, t2, ch);
    chk(t1 >= 0 && t2 >= 0 && (t2 - t1) == expP, tag, t2 - t1, expP);
    rd[c] = 8'd128;
    repeat (3) @(negedge clk);
    pulseClr(NCH'(1) << c);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    int t, ch, cnt;
    bit ef, ew;
    for (int i = 0; i < NCH; i++) begin
      rd[i] = 8'd128; fh[i] = 8'd250; fl[i] = 8'd5; wh[i] = 8'd240; wl[i] = 8'd10;
    end
    fh[0] = 8'd200; fl[0] = 8'd40; wh[0] = 8'd180; wl[0] = 8'd60;

    // R1: reset state
    activeRails = RW'(1);
    rd[0] = 8'd255;
    rd[2] = 8'd255;
    repeat (3) @(negedge clk);
    chk(faultFlags == '0 && warnFlags == '0, "R1 flags at reset", int'(faultFlags | warnFlags), 0);
    chk(faultEvt == 1'b0, "R1 evt at reset", int'(faultEvt), 0);
    rstN = 1'b1;

    // R9: voltage served before current in the same tick
    waitEvt(-1, t, ch);
    chk(ch == 0, "R9 first served channel", ch, 0);
    waitEvt(-1, t, ch);
    chk(ch == NR, "R9 second served channel", ch, NR);
    rd[0] = 8'd128;
    rd[2] = 8'd128;
    repeat (5) @(negedge clk);
    pulseClr('1);

    // R11: rails beyond activeRails untouched
    rd[1] = 8'd255;
    rd[NR + 1] = 8'd255;
    repeat (300) @(negedge clk);
    chk(faultFlags[1] == 1'b0 && warnFlags[1] == 1'b0, "R11 inactive voltage rail", int'(faultFlags[1]), 0);
    chk(faultFlags[NR+1] == 1'b0, "R11 inactive current rail", int'(faultFlags[NR+1]), 0);
    rd[1] = 8'd128;
    rd[NR + 1] = 8'd128;
    activeRails = RW'(NR);
    repeat (5) @(negedge clk);
    pulseClr('1);

    // R2, R3: sweep every code on channel 0
    for (int v = 0; v < 256; v++) begin
      @(negedge clk) rd[0] = W'(v);
      repeat (3) @(negedge clk);
      pulseClr(NCH'(1));
      repeat (2 * VUS * DIV + 6) @(negedge clk);
      ef = (v > 200) || (v < 40);
      ew = (v > 180) || (v < 60);
      chk(faultFlags[0] == ef, $sformatf("R2 fault flag at code %0d", v), int'(faultFlags[0]), int'(ef));
      chk(warnFlags[0] == ew, $sformatf("R3 warning flag at code %0d", v), int'(warnFlags[0]), int'(ew));
    end

    // R4, R5, R10: sticky, per-channel clear, single event
    pulseClr('1);
    rd[0] = 8'd255;
    rd[1] = 8'd0;
    repeat (3 * VUS * DIV) @(negedge clk);
    rd[0] = 8'd128;
    rd[1] = 8'd128;
    cnt = 0;
    for (int k = 0; k < 4 * VUS * DIV; k++) begin
      @(negedge clk);
      if (faultEvt) cnt++;
    end
    chk(cnt == 0, "R10 no repeat event while held", cnt, 0);
    chk(faultFlags[1:0] == 2'b11 && warnFlags[1:0] == 2'b11, "R4 flags held after recovery",
        int'({warnFlags[1:0], faultFlags[1:0]}), 15);
    pulseClr(NCH'(1));
    repeat (2) @(negedge clk);
    chk(faultFlags[0] == 1'b0 && warnFlags[0] == 1'b0, "R5 cleared channel", int'(faultFlags[0]), 0);
    chk(faultFlags[1] == 1'b1 && warnFlags[1] == 1'b1, "R5 neighbour untouched", int'(faultFlags[1]), 1);
    pulseClr('1);

    // R10: event carries index of the input-voltage channel
    rd[2*NR] = 8'd0;
    waitEvt(-1, t, ch);
    chk(ch == 2 * NR, "R10 event channel index", ch, 2 * NR);
    rd[2*NR] = 8'd128;
    repeat (3) @(negedge clk);
    pulseClr('1);

    // R6, R7, R8: check intervals
    measure(0, VUS * DIV, "R6 voltage interval");
    measure(NR + 1, VUS * 2 * DIV, "R7 current interval two rails");
    activeRails = RW'(1);
    measure(NR, VUS * DIV, "R7 current interval one rail");
    activeRails = RW'(0);
    measure(NR, VUS * DIV, "R7 current interval zero rails as one");
    activeRails = RW'(NR);
    measure(2 * NR, VINUS * DIV, "R8 input voltage interval");
    measure(2 * NR + 2, TUS * DIV, "R8 temperature interval");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule